// File: doc/BRIEF.md
# Eight-bit Arithmetic and Logic Unit with Decimal Add

This block is the arithmetic core of a small 8-bit processor. It takes two operand bytes, a 4-bit operation code, and the incoming carry, zero, overflow, negative and decimal-mode flags. It produces a result byte and the four updated condition flags. Operand A is the accumulator-side input. Operand B is the fetched value, and it is also the byte that increment, decrement, shift and rotate act on.

Instruction decode, register writeback and memory access are handled by the surrounding datapath. The combinational function sits behind a single output register, so every result and flag appears one clock after its inputs were presented. A synchronous active-high reset clears that register.

Add and subtract honour the decimal-mode input. The decimal correction is applied to the low byte of the binary sum, not per nibble with a half carry. Subtract is built by adding the complemented operand and then, when no carry came in, taking one more away.

Top module: `alu8_core`

## Requirements
- R1: Result and flag outputs are registered: values computed from the inputs present at a rising clock edge appear after that edge and hold until the next one. A clock edge with `rst` high clears the result and all four flag outputs to zero.
- R2: Code 0 with `dec_in` low adds A, B and `c_in` into a 9-bit sum. The result is its low byte and carry is its ninth bit. Overflow is set when A and B share a sign bit and the result's sign bit differs from it.
- R3: Code 0 with `dec_in` high takes the low byte of the same 9-bit sum. It adds 0x06 when that byte's low nibble is above 9, and 0x60 when the 9-bit sum is above 0x99, wrapping to 8 bits. Carry is set when the sum is above 0x99, and overflow is always cleared.
- R4: Code 1 performs the code-0 operation (same decimal handling) on A, the bitwise complement of B and a forced carry-in of 1. Carry and overflow come from that add. When `c_in` was low, the result is then reduced by one and zero and negative follow the reduced value.
- R5: Codes 2, 3 and 4 return A OR B, A AND B and A XOR B. Carry and overflow pass through unchanged.
- R6: Code 5 compares A with B. Carry is set when A is greater than or equal to B, unsigned. Zero and negative come from A minus B. The result output returns A unchanged, and overflow passes through.
- R7: Code 6 is a bit test. Zero is set when A AND B is zero, negative copies B bit 7, and overflow copies B bit 6. Carry passes through and the result output returns A.
- R8: Codes 7 and 8 return B plus one and B minus one, wrapping. Carry and overflow pass through unchanged.
- R9: Codes 9 and 10 shift B left and right by one, filling with zero. Codes 11 and 12 rotate B left and right through carry, with the old carry entering bit 0 on a left rotate and bit 7 on a right rotate. In all four, the bit shifted out becomes the new carry and overflow passes through.
- R10: Except for bit test, zero is set when the result byte is zero and negative copies result bit 7. Codes 13 to 15 return A with all four flags passed through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| opa | input | 8 | Operand A (accumulator side) |
| opb | input | 8 | Operand B (fetched value, target of inc/dec/shift) |
| c_in | input | 1 | Incoming carry flag |
| z_in | input | 1 | Incoming zero flag |
| v_in | input | 1 | Incoming overflow flag |
| n_in | input | 1 | Incoming negative flag |
| dec_in | input | 1 | Decimal-mode flag |
| res | output | 8 | Registered result |
| c_out | output | 1 | Registered carry flag |
| z_out | output | 1 | Registered zero flag |
| v_out | output | 1 | Registered overflow flag |
| n_out | output | 1 | Registered negative flag |

## Verification
Every result and flag is due exactly one rising edge after its operands and code are applied, because the only register in the path is the output stage. The bench drives inputs on the falling edge and samples on the following falling edge, one full edge later. A directed test also samples just after driving, before the edge, to confirm that the outputs still hold the previous operation's values. The reset check samples on the falling edge after a reset edge, when the cleared values must be visible.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W = 8;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_OR  = 4'd2,
    OP_AND = 4'd3,
    OP_XOR = 4'd4,
    OP_CMP = 4'd5,
    OP_BIT = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8,
    OP_ASL = 4'd9,
    OP_LSR = 4'd10,
    OP_ROL = 4'd11,
    OP_ROR = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int DW = alu8_pkg::DATA_W
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          dec,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          cout,
  output logic          vout
);
  localparam int SW = DW + 1;

  logic [DW-1:0] b_eff;
  logic          cin_eff;
  logic [SW-1:0] raw;
  logic [DW-1:0] bin_res;
  logic [DW-1:0] ov_vec;
  logic [DW-1:0] pre_res;
  logic          pre_c;
  logic          pre_v;

  assign b_eff   = sub ? ~b : b;
  assign cin_eff = sub ? 1'b1 : cin;
  assign raw     = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin_eff};
  assign bin_res = raw[DW-1:0];
  assign ov_vec  = ~(a ^ b_eff) & (a ^ bin_res);

  generate
    if (DW == 8) begin : g_decimal
      logic       lo_fix;
      logic       hi_fix;
      logic [7:0] adj;
      assign lo_fix = bin_res[3:0] > 4'd9;
      assign hi_fix = raw > 9'h099;
      assign adj    = {(hi_fix ? 4'h6 : 4'h0), (lo_fix ? 4'h6 : 4'h0)};
      always_comb begin
        if (dec) begin
          pre_res = bin_res + adj;
          pre_c   = hi_fix;
          pre_v   = 1'b0;
        end else begin
          pre_res = bin_res;
          pre_c   = raw[DW];
          pre_v   = ov_vec[DW-1];
        end
      end
    end else begin : g_binary_only
      assign pre_res = bin_res;
      assign pre_c   = raw[DW];
      assign pre_v   = ov_vec[DW-1] | (dec & 1'b0);
    end
  endgenerate

  // Subtract without incoming carry takes one further unit away.
  assign sum  = (sub && !cin) ? pre_res - {{(DW-1){1'b0}}, 1'b1} : pre_res;
  assign cout = pre_c;
  assign vout = pre_v;

endmodule

// File: rtl/alu8_misc.sv
module alu8_misc #(
  parameter int DW = alu8_pkg::DATA_W
) (
  input  logic [3:0]           op,
  input  logic [DW-1:0]        a,
  input  logic [DW-1:0]        b,
  input  alu8_pkg::alu_flags_t fin,
  output logic [DW-1:0]        res,
  output alu8_pkg::alu_flags_t fout
);
  import alu8_pkg::*;

  logic [DW-1:0] diff;
  logic [DW-1:0] zn_src;
  logic          zn_pass;
  logic          bit_test;

  assign diff = a - b;

  always_comb begin
    res      = a;
    fout     = fin;
    zn_src   = a;
    zn_pass  = 1'b0;
    bit_test = 1'b0;
    case (op)
      OP_OR:  begin res = a | b; zn_src = res; end
      OP_AND: begin res = a & b; zn_src = res; end
      OP_XOR: begin res = a ^ b; zn_src = res; end
      OP_CMP: begin res = a; zn_src = diff; fout.c = (a >= b); end
      OP_BIT: begin res = a; bit_test = 1'b1; end
      OP_INC: begin res = b + {{(DW-1){1'b0}}, 1'b1}; zn_src = res; end
      OP_DEC: begin res = b - {{(DW-1){1'b0}}, 1'b1}; zn_src = res; end
      OP_ASL: begin res = {b[DW-2:0], 1'b0};  fout.c = b[DW-1]; zn_src = res; end
      OP_LSR: begin res = {1'b0, b[DW-1:1]};  fout.c = b[0];    zn_src = res; end
      OP_ROL: begin res = {b[DW-2:0], fin.c}; fout.c = b[DW-1]; zn_src = res; end
      OP_ROR: begin res = {fin.c, b[DW-1:1]}; fout.c = b[0];    zn_src = res; end
      default: begin res = a; zn_pass = 1'b1; end
    endcase
    if (bit_test) begin
      fout.z = ((a & b) == '0);
      fout.n = b[DW-1];
      fout.v = b[DW-2];
    end else if (!zn_pass) begin
      fout.z = (zn_src == '0);
      fout.n = zn_src[DW-1];
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int DW = alu8_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          c_in,
  input  logic          z_in,
  input  logic          v_in,
  input  logic          n_in,
  input  logic          dec_in,
  output logic [DW-1:0] res,
  output logic          c_out,
  output logic          z_out,
  output logic          v_out,
  output logic          n_out
);
  import alu8_pkg::*;

  alu_flags_t    fin;
  alu_flags_t    misc_f;
  alu_flags_t    nxt_f;
  logic [DW-1:0] add_sum;
  logic          add_c;
  logic          add_v;
  logic [DW-1:0] misc_res;
  logic [DW-1:0] nxt_res;
  logic          is_arith;

  assign fin      = '{n: n_in, v: v_in, z: z_in, c: c_in};
  assign is_arith = (op_sel == OP_ADD) || (op_sel == OP_SUB);

  alu8_adder #(.DW(DW)) u_add (
    .a    (opa),
    .b    (opb),
    .cin  (c_in),
    .dec  (dec_in),
    .sub  (op_sel == OP_SUB),
    .sum  (add_sum),
    .cout (add_c),
    .vout (add_v)
  );

  alu8_misc #(.DW(DW)) u_misc (
    .op   (op_sel),
    .a    (opa),
    .b    (opb),
    .fin  (fin),
    .res  (misc_res),
    .fout (misc_f)
  );

  always_comb begin
    if (is_arith) begin
      nxt_res = add_sum;
      nxt_f   = '{n: add_sum[DW-1], v: add_v, z: (add_sum == '0), c: add_c};
    end else begin
      nxt_res = misc_res;
      nxt_f   = misc_f;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res   <= '0;
      c_out <= 1'b0;
      z_out <= 1'b0;
      v_out <= 1'b0;
      n_out <= 1'b0;
    end else begin
      res   <= nxt_res;
      c_out <= nxt_f.c;
      z_out <= nxt_f.z;
      v_out <= nxt_f.v;
      n_out <= nxt_f.n;
    end
  end

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int DW = alu8_pkg::DATA_W
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    op_sel,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic          c_in,
  input logic          v_in,
  input logic          dec_in,
  input logic [DW-1:0] res,
  input logic          c_out,
  input logic          z_out,
  input logic          v_out,
  input logic          n_out
);
  import alu8_pkg::*;

  logic rst_q = 1'b0;

  always_ff @(posedge clk) rst_q <= rst;

  // R1: a reset edge leaves every output at zero
  always @(posedge clk) begin
    if (rst_q) begin
      a_r1_reset_clears: assert (res == '0 && !c_out && !z_out && !v_out && !n_out)
        else $error("R1 outputs not cleared after reset");
    end
  end

  a_r3_dec_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ADD && dec_in) |=> !v_out);

  a_r5_logic_keeps_cv: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_OR || op_sel == OP_AND || op_sel == OP_XOR)
      |=> (c_out == $past(c_in) && v_out == $past(v_in)));

  a_r6_cmp_returns_a: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_CMP) |=> (res == $past(opa)));

  a_r7_bit_keeps_carry: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_BIT) |=> (c_out == $past(c_in) && v_out == $past(opb[DW-2])));

  a_r8_incdec_keep_cv: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_INC || op_sel == OP_DEC)
      |=> (c_out == $past(c_in) && v_out == $past(v_in)));

  a_r9_asl_carry_out: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_ASL) |=> (c_out == $past(opb[DW-1])));

  a_r10_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (op_sel == OP_INC) |=> (z_out == (res == '0)));

endmodule

bind alu8_core alu8_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op_sel (op_sel),
  .opa    (opa),
  .opb    (opb),
  .c_in   (c_in),
  .v_in   (v_in),
  .dec_in (dec_in),
  .res    (res),
  .c_out  (c_out),
  .z_out  (z_out),
  .v_out  (v_out),
  .n_out  (n_out)
);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  // vector: op(4) a(8) b(8) fin{d,n,v,z,c}(5) res(8) fout{n,v,z,c}(4)
  localparam int NV = 27;
  localparam logic [36:0] VEC [NV] = '{
    {4'd0,  8'h50, 8'h50, 5'b00000, 8'hA0, 4'b1100}, // R2 signed overflow
    {4'd0,  8'hFF, 8'h01, 5'b00000, 8'h00, 4'b0011}, // R2 carry out, zero
    {4'd0,  8'h10, 8'h20, 5'b00001, 8'h31, 4'b0000}, // R2 carry in
    {4'd0,  8'h19, 8'h28, 5'b10100, 8'h41, 4'b0000}, // R3 no nibble fix, V cleared
    {4'd0,  8'h15, 8'h27, 5'b10000, 8'h42, 4'b0000}, // R3 low fix
    {4'd0,  8'h58, 8'h46, 5'b10001, 8'h05, 4'b0001}, // R3 both fixes, carry
    {4'd1,  8'h50, 8'h30, 5'b00001, 8'h20, 4'b0001}, // R4 carry set
    {4'd1,  8'h50, 8'h30, 5'b00000, 8'h1F, 4'b0001}, // R4 extra decrement
    {4'd1,  8'h00, 8'h01, 5'b00001, 8'hFF, 4'b1000}, // R4 borrow
    {4'd1,  8'h80, 8'h01, 5'b00001, 8'h7F, 4'b0101}, // R4 overflow
    {4'd1,  8'h01, 8'h00, 5'b00000, 8'h00, 4'b0011}, // R4 decrement to zero
    {4'd1,  8'h10, 8'h01, 5'b10001, 8'h75, 4'b0001}, // R4 decimal path
    {4'd2,  8'hF0, 8'h0F, 5'b00101, 8'hFF, 4'b1101}, // R5 or
    {4'd3,  8'hF0, 8'h0F, 5'b00000, 8'h00, 4'b0010}, // R5 and
    {4'd4,  8'hAA, 8'hFF, 5'b00001, 8'h55, 4'b0001}, // R5 xor
    {4'd5,  8'h40, 8'h40, 5'b00100, 8'h40, 4'b0111}, // R6 equal
    {4'd5,  8'h10, 8'h20, 5'b00000, 8'h10, 4'b1000}, // R6 less
    {4'd6,  8'h0F, 8'hC0, 5'b00001, 8'h0F, 4'b1111}, // R7 bits set
    {4'd6,  8'hFF, 8'h01, 5'b01110, 8'hFF, 4'b0000}, // R7 bits clear
    {4'd7,  8'h00, 8'hFF, 5'b00101, 8'h00, 4'b0111}, // R8 inc wrap
    {4'd8,  8'h00, 8'h00, 5'b00000, 8'hFF, 4'b1000}, // R8 dec wrap
    {4'd9,  8'h00, 8'h81, 5'b00000, 8'h02, 4'b0001}, // R9 asl
    {4'd10, 8'h00, 8'h01, 5'b00000, 8'h00, 4'b0011}, // R9 lsr
    {4'd11, 8'h00, 8'h80, 5'b00001, 8'h01, 4'b0001}, // R9 rol
    {4'd12, 8'h00, 8'h01, 5'b00001, 8'h80, 4'b1001}, // R9 ror carry in
    {4'd12, 8'h00, 8'h02, 5'b00000, 8'h01, 4'b0000}, // R9 ror no carry
    {4'd13, 8'h33, 8'h00, 5'b01111, 8'h33, 4'b1111}  // R10 reserved code
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] opa = 8'h00;
  logic [7:0] opb = 8'h00;
  logic       c_in = 1'b0, z_in = 1'b0, v_in = 1'b0, n_in = 1'b0, dec_in = 1'b0;
  logic [7:0] res;
  logic       c_out, z_out, v_out, n_out;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb),
    .c_in(c_in), .z_in(z_in), .v_in(v_in), .n_in(n_in), .dec_in(dec_in),
    .res(res), .c_out(c_out), .z_out(z_out), .v_out(v_out), .n_out(n_out)
  );

  function automatic string tag_of(input logic [3:0] op, input logic d);
    case (op)
      4'd0:  return d ? "R3" : "R2";
      4'd1:  return "R4";
      4'd2, 4'd3, 4'd4: return "R5";
      4'd5:  return "R6";
      4'd6:  return "R7";
      4'd7, 4'd8: return "R8";
      4'd9, 4'd10, 4'd11, 4'd12: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] exp_r, input logic [3:0] exp_f);
    logic [3:0] got_f;
    got_f = {n_out, v_out, z_out, c_out};
    total++;
    if (res !== exp_r || got_f !== exp_f) begin
      bad++;
      $display("FAIL %s res=%02h flags(nvzc)=%04b expected res=%02h flags=%04b",
               tag, res, got_f, exp_r, exp_f);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [4:0] f);
    op_sel = op; opa = a; opb = b;
    {dec_in, n_in, v_in, z_in, c_in} = f;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", 8'h00, 4'b0000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][36:33], VEC[i][32:25], VEC[i][24:17], VEC[i][16:12]);
      @(negedge clk);
      check(tag_of(VEC[i][36:33], VEC[i][16]), VEC[i][11:4], VEC[i][3:0]);
    end

    // R1 output holds until the clock edge, then updates
    drive(4'd0, 8'h01, 8'h01, 5'b00000);
    #1;
    check("R1", 8'h33, 4'b1111);
    @(negedge clk);
    check("R1", 8'h02, 4'b0000);

    // R9 rotate chain: carry from one rotate feeds the next
    drive(4'd11, 8'h00, 8'hC0, 5'b00000);
    @(negedge clk);
    check("R9", 8'h80, 4'b1001);
    drive(4'd11, 8'h00, 8'h80, {1'b0, n_out, v_out, z_out, c_out});
    @(negedge clk);
    check("R9", 8'h01, 4'b0001);

    // R10 zero flag from a result of zero on xor
    drive(4'd4, 8'h5A, 8'h5A, 5'b00000);
    @(negedge clk);
    check("R10", 8'h00, 4'b0010);

    // R1 reset applied over a nonzero output
    drive(4'd2, 8'hFF, 8'h00, 5'b00101);
    @(negedge clk);
    check("R5", 8'hFF, 4'b1101);
    rst = 1'b1;
    @(negedge clk);
    check("R1", 8'h00, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 8'hFF, 4'b1101);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule